// File: doc/BRIEF.md
# Processor interrupt entry controller

This block is the hardware half of taking an interruption in a small RISC core. Each cycle it looks at four kinds of pending request: a 32-line external request word, a low-priority machine check, a powerfail warning and a high-priority machine check. It also sees the core's current status word, privilege level, vector base register and seven general registers. When it accepts a request, it does several things in one step. It saves the old status word and privilege. It builds a fresh status word for the handler and sets privilege to zero. It copies the seven registers into shadow copies. It then issues a one-cycle redirect carrying the handler fetch address.

The core writes back the new status word and privilege from the block's state write bus. A return request reverses the entry. It puts the saved status word and privilege on the same bus and presents the shadow registers for write-back to the register file. Instruction execution, address translation and the handler code itself belong elsewhere.

Top module: `intr_entry_top`

## Requirements
- R1: When an interruption is taken, in the cycle after the take edge `saved_status` equals the `cur_status` value and `saved_priv` equals the `cur_priv` value sampled at that edge.
- R2: A take writes privilege 0 and a new status word. In the cycle after the take edge, `state_wr_valid` is 1 and `priv_wr_data` is 0.
- R3: The entry status word on `status_wr_data` has bit 5 (endian) equal to the `ENDIAN_DEFAULT` parameter (default 1). It has bit 6 (machine-check flag) equal to 1 only for a high-priority machine check. Every other bit is 0, which includes bit 0 (interrupt enable), bit 1 (code translation), bit 2 (data translation), bit 3 (protection) and bit 4 (queue enable).
- R4: On a take, the seven 32-bit slices of `gr_in` are copied into `gr_shadow` in one cycle. Slice k sits at bits [32k+31:32k], and slices 0 to 6 carry r1, r8, r9, r16, r17, r24 and r25 in that order.
- R5: `redirect_addr` equals the sampled `vec_base` plus 32 times `vector_out`, modulo 2^32.
- R6: Pending causes resolve by fixed priority, and each cause has its own vector. A high-priority machine check takes vector 1, powerfail vector 2, low-priority machine check vector 3, and any nonzero `ext_req` line vector 4.
- R7: While `cur_status` bit 0 is 0, external, powerfail and low-priority machine check requests are ignored and produce no redirect. A high-priority machine check is still taken.
- R8: `redirect_valid` is high for exactly one cycle per take. No take is accepted at the edge right after a take, so a held request redirects every second cycle.
- R9: A `rfi_req` sampled at an edge with no take makes the next cycle show `state_wr_valid` = 1, `gr_wr_valid` = 1, `status_wr_data` = saved status, `priv_wr_data` = saved privilege and `gr_shadow` = the registers copied at entry. A `rfi_req` at a take edge is ignored.
- R10: After reset, `redirect_valid`, `state_wr_valid` and `gr_wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 32 | External request lines |
| lpmc_req | input | 1 | Low-priority machine check request |
| pwrf_req | input | 1 | Powerfail request |
| hpmc_req | input | 1 | High-priority machine check request, not maskable |
| rfi_req | input | 1 | Return from interruption |
| cur_status | input | 32 | Current status word, bit 0 is interrupt enable |
| cur_priv | input | 2 | Current privilege level |
| vec_base | input | 32 | Vector base address |
| gr_in | input | 224 | r1, r8, r9, r16, r17, r24, r25, slice 0 first |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_addr | output | 32 | Handler fetch address |
| vector_out | output | 5 | Vector number of the taken cause |
| state_wr_valid | output | 1 | Status and privilege write strobe |
| status_wr_data | output | 32 | Status word to write |
| priv_wr_data | output | 2 | Privilege to write |
| saved_status | output | 32 | Saved status word |
| saved_priv | output | 2 | Saved privilege |
| gr_shadow | output | 224 | Shadow register bank |
| gr_wr_valid | output | 1 | Register restore strobe |

## Verification
The bench sweeps all 32 combinations of the four cause flags and the enable bit. This separates priority order from masking: the same request set must give vector 1, 2, 3, 4 or no redirect depending on which flags are set and on the enable bit. Each of the 32 external lines is then raised alone, to show that every line lands on vector 4. A held machine check shows the one-cycle redirect spacing. A return issued together with a take must be ignored. Each taken case ends with a return, and the bench compares the restored status, privilege and registers with the pre-entry values after the register inputs have been scrambled.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    localparam int SW_W  = 32;
    localparam int VEC_W = 5;

    // status word bit positions
    localparam int SB_IEN  = 0;
    localparam int SB_CTRN = 1;
    localparam int SB_DTRN = 2;
    localparam int SB_PROT = 3;
    localparam int SB_QEN  = 4;
    localparam int SB_END  = 5;
    localparam int SB_MCK  = 6;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_HPMC,
        CAUSE_PWRF,
        CAUSE_LPMC,
        CAUSE_EXT
    } cause_e;

    typedef struct packed {
        logic hpmc;
        logic pwrf;
        logic lpmc;
        logic ext;
    } req_t;

    function automatic logic [VEC_W-1:0] vector_of(cause_e c);
        case (c)
            CAUSE_HPMC: return VEC_W'(1);
            CAUSE_PWRF: return VEC_W'(2);
            CAUSE_LPMC: return VEC_W'(3);
            CAUSE_EXT:  return VEC_W'(4);
            default:    return '0;
        endcase
    endfunction

    function automatic logic [SW_W-1:0] entry_status(logic endian_dflt, logic high_check);
        logic [SW_W-1:0] s;
        s         = '0;
        s[SB_END] = endian_dflt;
        s[SB_MCK] = high_check;
        return s;
    endfunction

endpackage

// File: rtl/intr_cause_arb.sv
module intr_cause_arb
    import intr_entry_pkg::*;
(
    input  req_t   req,
    input  logic   ien,
    output logic   valid,
    output cause_e cause
);
    always_comb begin
        if (req.hpmc)             cause = CAUSE_HPMC;
        else if (ien && req.pwrf) cause = CAUSE_PWRF;
        else if (ien && req.lpmc) cause = CAUSE_LPMC;
        else if (ien && req.ext)  cause = CAUSE_EXT;
        else                      cause = CAUSE_NONE;
        valid = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/intr_vector_gen.sv
module intr_vector_gen #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 5,
    parameter int SHIFT  = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - VEC_W;
    logic [ADDR_W-1:0] vec_ext;
    assign vec_ext = {{PAD_W{1'b0}}, vec};
    assign addr    = base + (vec_ext << SHIFT);
endmodule

// File: rtl/intr_shadow_bank.sv
module intr_shadow_bank #(
    parameter int N = 7,
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N*W-1:0] d,
    output logic [N*W-1:0] q
);
    for (genvar k = 0; k < N; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)       q[k*W +: W] <= '0;
            else if (load) q[k*W +: W] <= d[k*W +: W];
        end
    end

    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d))); // R4
endmodule

// File: rtl/intr_entry_top.sv
module intr_entry_top
    import intr_entry_pkg::*;
#(
    parameter int   EXT_N          = 32,
    parameter int   ADDR_W         = 32,
    parameter int   PRIV_W         = 2,
    parameter int   NUM_SHADOW     = 7,
    parameter int   VEC_SHIFT      = 5,
    parameter logic ENDIAN_DEFAULT = 1'b1,
    localparam int  GR_W           = NUM_SHADOW * SW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EXT_N-1:0]  ext_req,
    input  logic              lpmc_req,
    input  logic              pwrf_req,
    input  logic              hpmc_req,
    input  logic              rfi_req,
    input  logic [SW_W-1:0]   cur_status,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [ADDR_W-1:0] vec_base,
    input  logic [GR_W-1:0]   gr_in,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic [VEC_W-1:0]  vector_out,
    output logic              state_wr_valid,
    output logic [SW_W-1:0]   status_wr_data,
    output logic [PRIV_W-1:0] priv_wr_data,
    output logic [SW_W-1:0]   saved_status,
    output logic [PRIV_W-1:0] saved_priv,
    output logic [GR_W-1:0]   gr_shadow,
    output logic              gr_wr_valid
);
    req_t              req;
    logic              arb_valid;
    cause_e            arb_cause;
    logic [VEC_W-1:0]  vec_next;
    logic [ADDR_W-1:0] addr_next;
    logic              take_now;
    logic              back_now;

    assign req = '{hpmc: hpmc_req, pwrf: pwrf_req, lpmc: lpmc_req, ext: |ext_req};

    intr_cause_arb u_arb (
        .req   (req),
        .ien   (cur_status[SB_IEN]),
        .valid (arb_valid),
        .cause (arb_cause)
    );

    assign vec_next = vector_of(arb_cause);

    intr_vector_gen #(
        .ADDR_W (ADDR_W),
        .VEC_W  (VEC_W),
        .SHIFT  (VEC_SHIFT)
    ) u_vec (
        .base (vec_base),
        .vec  (vec_next),
        .addr (addr_next)
    );

    // a take blocks the next edge; a return loses to a take
    assign take_now = arb_valid && !redirect_valid;
    assign back_now = rfi_req && !take_now;

    intr_shadow_bank #(
        .N (NUM_SHADOW),
        .W (SW_W)
    ) u_shadow (
        .clk  (clk),
        .rst  (rst),
        .load (take_now),
        .d    (gr_in),
        .q    (gr_shadow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_addr  <= '0;
            vector_out     <= '0;
            state_wr_valid <= 1'b0;
            status_wr_data <= '0;
            priv_wr_data   <= '0;
            saved_status   <= '0;
            saved_priv     <= '0;
            gr_wr_valid    <= 1'b0;
        end else begin
            redirect_valid <= take_now;
            state_wr_valid <= take_now || back_now;
            gr_wr_valid    <= back_now;
            if (take_now) begin
                redirect_addr  <= addr_next;
                vector_out     <= vec_next;
                status_wr_data <= entry_status(ENDIAN_DEFAULT, arb_cause == CAUSE_HPMC);
                priv_wr_data   <= '0;
                saved_status   <= cur_status;
                saved_priv     <= cur_priv;
            end else if (back_now) begin
                status_wr_data <= saved_status;
                priv_wr_data   <= saved_priv;
            end
        end
    end

    AST_ONE_CYCLE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid); // R8
    AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!cur_status[SB_IEN] && !hpmc_req) |=> !redirect_valid); // R7
    AST_HPMC_ALWAYS: assert property (@(posedge clk) disable iff (rst)
        (hpmc_req && !redirect_valid) |=> (redirect_valid && vector_out == VEC_W'(1))); // R6
    AST_SAVE_STATE: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (saved_status == $past(cur_status) && saved_priv == $past(cur_priv))); // R1
    AST_ENTRY_PRIV: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (state_wr_valid && priv_wr_data == '0 && !gr_wr_valid)); // R2
    AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> ((status_wr_data & ~(SW_W'(1) << SB_END) & ~(SW_W'(1) << SB_MCK)) == '0
                            && status_wr_data[SB_END] == ENDIAN_DEFAULT
                            && status_wr_data[SB_MCK] == (vector_out == VEC_W'(1)))); // R3
    AST_TARGET_ADDR: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (redirect_addr ==
            $past(vec_base) + ({{(ADDR_W-VEC_W){1'b0}}, vector_out} << VEC_SHIFT))); // R5
    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (rst)
        gr_wr_valid |-> (state_wr_valid && status_wr_data == saved_status
                         && priv_wr_data == saved_priv && !redirect_valid)); // R9
endmodule

// File: tb/intr_entry_top_bench.sv
module intr_entry_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [31:0]  ext_req = '0;
    logic         lpmc_req = 1'b0, pwrf_req = 1'b0, hpmc_req = 1'b0, rfi_req = 1'b0;
    logic [31:0]  cur_status = '0;
    logic [1:0]   cur_priv = '0;
    logic [31:0]  vec_base = '0;
    logic [223:0] gr_in = '0;
    logic         redirect_valid, state_wr_valid, gr_wr_valid;
    logic [31:0]  redirect_addr, status_wr_data, saved_status;
    logic [4:0]   vector_out;
    logic [1:0]   priv_wr_data, saved_priv;
    logic [223:0] gr_shadow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    intr_entry_top u_intr_entry_top (
        .clk(clk), .rst(rst), .ext_req(ext_req), .lpmc_req(lpmc_req),
        .pwrf_req(pwrf_req), .hpmc_req(hpmc_req), .rfi_req(rfi_req),
        .cur_status(cur_status), .cur_priv(cur_priv), .vec_base(vec_base),
        .gr_in(gr_in), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .vector_out(vector_out), .state_wr_valid(state_wr_valid),
        .status_wr_data(status_wr_data), .priv_wr_data(priv_wr_data),
        .saved_status(saved_status), .saved_priv(saved_priv),
        .gr_shadow(gr_shadow), .gr_wr_valid(gr_wr_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        hpmc_req = 0; pwrf_req = 0; lpmc_req = 0; ext_req = '0; rfi_req = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(redirect_valid == 0, "R10 redirect", {31'd0, redirect_valid}, 0);
        chk(state_wr_valid == 0, "R10 state_wr", {31'd0, state_wr_valid}, 0);
        chk(gr_wr_valid == 0, "R10 gr_wr", {31'd0, gr_wr_valid}, 0);

        // sweep cause flags x enable bit
        for (int c = 0; c < 32; c++) begin
            logic hp, pw, lp, ex, ien, taken;
            logic [31:0] st, base, exp_stat;
            logic [1:0]  pr;
            logic [4:0]  exp_vec;
            logic [31:0] grv [7];
            hp = c[0]; pw = c[1]; lp = c[2]; ex = c[3]; ien = c[4];
            st   = ((32'h5A3C_0F00 ^ (c * 32'h0101_0111)) & ~32'h1) | {31'd0, ien};
            pr   = 2'(c) ^ 2'b10;
            base = 32'h4000_0000 + c * 32'h0001_0040;
            for (int k = 0; k < 7; k++) grv[k] = 32'hCAFE_0000 + c * 32'h100 + k * 7;
            taken   = hp || (ien && (pw || lp || ex));
            exp_vec = hp ? 5'd1 : pw ? 5'd2 : lp ? 5'd3 : 5'd4;
            exp_stat = (32'h1 << 5) | ({31'd0, hp} << 6);

            hpmc_req = hp; pwrf_req = pw; lpmc_req = lp;
            ext_req = ex ? (32'h1 << c) : 32'h0;
            cur_status = st; cur_priv = pr; vec_base = base;
            for (int k = 0; k < 7; k++) gr_in[k*32 +: 32] = grv[k];
            @(negedge clk);
            chk(redirect_valid == taken, "R7 take vs mask", {31'd0, redirect_valid}, {31'd0, taken});
            if (taken) begin
                chk(vector_out == exp_vec, "R6 vector", {27'd0, vector_out}, {27'd0, exp_vec});
                chk(redirect_addr == base + 32 * exp_vec, "R5 addr", redirect_addr, base + 32 * exp_vec);
                chk(status_wr_data == exp_stat, "R3 entry status", status_wr_data, exp_stat);
                chk(state_wr_valid && priv_wr_data == 0, "R2 priv", {30'd0, priv_wr_data}, 0);
                chk(saved_status == st, "R1 saved status", saved_status, st);
                chk(saved_priv == pr, "R1 saved priv", {30'd0, saved_priv}, {30'd0, pr});
                for (int k = 0; k < 7; k++)
                    chk(gr_shadow[k*32 +: 32] == grv[k], "R4 shadow", gr_shadow[k*32 +: 32], grv[k]);
            end else begin
                chk(state_wr_valid == 0, "R7 no write", {31'd0, state_wr_valid}, 0);
            end
            // core applies entry state, handler clobbers registers
            idle();
            cur_status = exp_stat; cur_priv = 2'd0;
            for (int k = 0; k < 7; k++) gr_in[k*32 +: 32] = ~grv[k];
            rfi_req = taken;
            @(negedge clk);
            chk(redirect_valid == 0, "R8 pulse", {31'd0, redirect_valid}, 0);
            if (taken) begin
                chk(state_wr_valid && gr_wr_valid, "R9 strobes", {30'd0, state_wr_valid, gr_wr_valid}, 32'h3);
                chk(status_wr_data == st, "R9 status", status_wr_data, st);
                chk(priv_wr_data == pr, "R9 priv", {30'd0, priv_wr_data}, {30'd0, pr});
                for (int k = 0; k < 7; k++)
                    chk(gr_shadow[k*32 +: 32] == grv[k], "R9 regs", gr_shadow[k*32 +: 32], grv[k]);
            end
            rfi_req = 0;
            @(negedge clk);
            chk(state_wr_valid == 0 && gr_wr_valid == 0, "R9 strobes drop",
                {30'd0, state_wr_valid, gr_wr_valid}, 0);
        end

        // every external line alone maps to vector 4
        for (int b = 0; b < 32; b++) begin
            idle();
            cur_status = 32'h1; vec_base = 32'h0010_0000 * b;
            ext_req = 32'h1 << b;
            @(negedge clk);
            chk(redirect_valid && vector_out == 5'd4, "R6 ext line", {27'd0, vector_out}, 32'd4);
            idle();
            @(negedge clk);
        end

        // held high-priority check: redirect every second cycle, even with enable off
        idle();
        cur_status = 32'h0;
        hpmc_req = 1;
        @(negedge clk);
        chk(redirect_valid == 1, "R8 held first", {31'd0, redirect_valid}, 1);
        @(negedge clk);
        chk(redirect_valid == 0, "R8 held gap", {31'd0, redirect_valid}, 0);
        @(negedge clk);
        chk(redirect_valid == 1, "R8 held again", {31'd0, redirect_valid}, 1);
        idle();
        @(negedge clk);

        // return at a take edge is ignored
        cur_status = 32'h1; pwrf_req = 1; rfi_req = 1;
        @(negedge clk);
        chk(redirect_valid && !gr_wr_valid, "R9 rfi ignored at take",
            {30'd0, redirect_valid, gr_wr_valid}, 32'h2);
        chk(vector_out == 5'd2, "R6 powerfail", {27'd0, vector_out}, 32'd2);
        idle();
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule